// File: doc/BRIEF.md
# Per-Pin Digital Glitch Filter

This block cleans up the digital inputs of one port of up to 32 pins. Each raw pin first passes through a two-flop synchroniser into the filter clock domain. It then reaches a per-pin filter that accepts a new level only once that level has held for longer than a programmed number of clock cycles. A change that lasts that many cycles or fewer is treated as a glitch and dropped, so the filtered output keeps its earlier level.

One length value, held in a 5-bit configuration register, sets the rejection threshold for every pin. Each pin has its own enable bit. A pin whose enable is clear drives its raw input straight to its output, with no synchroniser and no register on the path. The length register can only be rewritten while every enable bit is clear. This keeps the threshold from moving under a filter that is counting. The filter acts the same way whatever function the pin is muxed to.

Top module: `pin_glitch_filter`

## Requirements
- R1: The length register resets to 0. A write (`cfg_wr` high for one cycle) that is accepted stores `cfg_wdata[4:0]`. The new value appears on `cfg_rdata[4:0]` in the next cycle. `cfg_rdata[31:5]` always reads 0, and `cfg_wdata[31:5]` has no effect.
- R2: A length write made while any bit of `filt_en` is set is ignored, and `cfg_rdata` keeps its value.
- R3: For an enabled pin, a level change that lasts no more than `len` cycles after synchronisation is absorbed, and `pin_out` keeps its previous level. This holds for both rising and falling glitches.
- R4: For an enabled pin, a level change that lasts more than `len` cycles reaches `pin_out` `len`+3 cycles after the raw change: two synchroniser cycles plus `len`+1 counting cycles. The pulse width is preserved.
- R5: With `len` = 0, any change lasting at least one cycle passes, with a latency of 3 cycles.
- R6: The qualification count restarts whenever the synchronised input returns to the current output level. Two short glitches separated by a single matching cycle are therefore each judged on their own length.
- R7: For a pin whose enable is clear, `pin_out` equals `pin_raw` combinationally.
- R8: A pin enabled while its raw input has been steady for at least three cycles shows that steady level at once, with no spurious transition. Each pin's filter acts independently of the others.
- R9: Filtering applies per pin, and the programmed length is common to all pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 32 | Raw, asynchronous pin levels |
| filt_en | input | 32 | Per-pin filter enable |
| cfg_wr | input | 1 | Length register write strobe |
| cfg_wdata | input | 32 | Length register write data |
| cfg_rdata | output | 32 | Length register read value |
| pin_out | output | 32 | Filtered pin levels |

## Verification
The hardest case to reach is the exact boundary between rejection and acceptance on many pins at once, for both polarities and for several lengths. This includes the full-scale length of 31, where only a 32-cycle pulse can pass. The bench gives pin i a pulse of i+1 cycles, all starting together. At each chosen length, one sweep therefore covers every width from 1 to 32. For every pin, it checks the number of output cycles and the cycle of the first output change against arithmetic expectations. A separate pattern of two glitches divided by one matching cycle forces the counter restart described in R6.

// File: rtl/pgf_pkg.sv
// Package: shared sizing constants for the pin glitch filter.
// Assumes: the configuration register is one 32-bit word.
package pgf_pkg;
    localparam int PGF_REG_W     = 32;
    localparam int PGF_SYNC_DEPTH = 2;
endpackage

// File: rtl/pgf_sync.sv
// Module: pgf_sync
// Brings a vector of asynchronous inputs into the clock domain through a
// chain of STAGES flops per bit.
// Assumes: each bit is independent; no bus coherency is needed.
module pgf_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pgf_len_reg.sv
// Module: pgf_len_reg
// Holds the shared filter length. A write is taken only when every
// per-pin enable is clear. The read value is zero above the length field.
// Assumes: REG_W > LEN_W.
module pgf_len_reg #(
    parameter int LEN_W    = 5,
    parameter int REG_W    = 32,
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NUM_PINS-1:0] filt_en,
    output logic [LEN_W-1:0]    len,
    output logic [REG_W-1:0]    rdata
);
    localparam int PAD_W = REG_W - LEN_W;

    logic all_off;
    assign all_off = (filt_en == '0);

    // Capture the length field only while all filters are off.
    always_ff @(posedge clk) begin
        if (!rst_n)               len <= '0;
        else if (wr && all_off)   len <= wdata[LEN_W-1:0];
    end

    assign rdata = {{PAD_W{1'b0}}, len};
endmodule

// File: rtl/pgf_pin_filter.sv
// Module: pgf_pin_filter
// One pin's qualifier. It counts consecutive cycles in which the synchronised
// input differs from the held level, and adopts the new level on the
// (len+1)-th such cycle. When disabled it tracks the input so that enabling
// it later causes no glitch.
// Assumes: sync_in is already in the clk domain.
module pgf_pin_filter #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync_in,
    input  logic [LEN_W-1:0] len,
    output logic             held
);
    logic [LEN_W-1:0] cnt;
    logic             differs;
    logic             expired;

    assign differs = (sync_in != held);
    assign expired = (cnt == len);

    // Qualify level changes against the shared length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (!en) begin
            held <= sync_in;
            cnt  <= '0;
        end else if (!differs) begin
            cnt  <= '0;
        end else if (expired) begin
            held <= sync_in;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pin_glitch_filter.sv
// Module: pin_glitch_filter
// Top level: synchroniser, shared length register and one qualifier per
// pin. A disabled pin bypasses the filter combinationally.
// Assumes: a single filter clock; analog paths live elsewhere.
module pin_glitch_filter #(
    parameter int NUM_PINS = 32,
    parameter int LEN_W    = 5,
    parameter int REG_W    = pgf_pkg::PGF_REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] filt_en,
    input  logic                cfg_wr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    output logic [NUM_PINS-1:0] pin_out
);
    logic [NUM_PINS-1:0] sync_bus;
    logic [NUM_PINS-1:0] held_bus;
    logic [LEN_W-1:0]    len;

    pgf_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (pgf_pkg::PGF_SYNC_DEPTH)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (sync_bus)
    );

    pgf_len_reg #(
        .LEN_W    (LEN_W),
        .REG_W    (REG_W),
        .NUM_PINS (NUM_PINS)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .filt_en (filt_en),
        .len     (len),
        .rdata   (cfg_rdata)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pgf_pin_filter #(.LEN_W(LEN_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (filt_en[i]),
            .sync_in (sync_bus[i]),
            .len     (len),
            .held    (held_bus[i])
        );
        // Select filtered or bypass level for this pin.
        assign pin_out[i] = filt_en[i] ? held_bus[i] : pin_raw[i];
    end
endmodule

// File: rtl/pgf_checker.sv
// Module: pgf_checker
// Temporal checks on the glitch filter. It keeps its own per-pin count of
// consecutive mismatch cycles between the synchronised input and the held level.
// Assumes: bound to pin_glitch_filter.
module pgf_checker #(
    parameter int NUM_PINS = 32,
    parameter int LEN_W    = 5,
    parameter int REG_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_raw,
    input logic [NUM_PINS-1:0] filt_en,
    input logic                cfg_wr,
    input logic [REG_W-1:0]    cfg_wdata,
    input logic [REG_W-1:0]    cfg_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] sync_bus,
    input logic [NUM_PINS-1:0] held_bus
);
    localparam int RUN_W = LEN_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] runc [NUM_PINS];
    logic [RUN_W-1:0] len_x;
    assign len_x = {1'b0, cfg_rdata[LEN_W-1:0]};

    // Count consecutive enabled mismatch cycles per pin, saturating.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PINS; i++) begin
            if (!rst_n || !filt_en[i] || sync_bus[i] == held_bus[i])
                runc[i] <= '0;
            else if (runc[i] != RUN_MAX)
                runc[i] <= runc[i] + 1'b1;
        end
    end

    p_len_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && filt_en == '0) |=>
        (cfg_rdata[LEN_W-1:0] == $past(cfg_wdata[LEN_W-1:0])
         && cfg_rdata[REG_W-1:LEN_W] == '0));

    p_len_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_en) != '0) |-> $stable(cfg_rdata));

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~filt_en) == (pin_raw & ~filt_en)));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        p_no_early_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_en[i] && $past(filt_en[i]) && pin_out[i] != $past(pin_out[i]))
            |-> ($past(runc[i]) >= $past(len_x)));

        p_pass_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(filt_en[i] && sync_bus[i] != held_bus[i] && runc[i] == len_x)
             && filt_en[i])
            |-> (pin_out[i] == $past(sync_bus[i])));
    end
endmodule

bind pin_glitch_filter pgf_checker #(
    .NUM_PINS (NUM_PINS),
    .LEN_W    (LEN_W),
    .REG_W    (REG_W)
) u_pgf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (pin_raw),
    .filt_en   (filt_en),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pin_out   (pin_out),
    .sync_bus  (sync_bus),
    .held_bus  (held_bus)
);

// File: tb/test_pin_glitch_filter.sv
// Bench: sweeps pulse widths 1..32 across the pins at several lengths and
// both polarities, and computes the expected widths and latencies arithmetically.
module test_pin_glitch_filter;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin_raw;
    logic [NP-1:0] filt_en;
    logic          cfg_wr;
    logic [31:0]   cfg_wdata;
    logic [31:0]   cfg_rdata;
    logic [NP-1:0] pin_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pin_glitch_filter i_pin_glitch_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw   (pin_raw),
        .filt_en   (filt_en),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pin_out   (pin_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_len(input logic [31:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Pin i gets a (i+1)-cycle pulse of polarity ~pol; check the width and first-change cycle.
    task automatic sweep(input int len, input bit pol);
        int cnt   [NP];
        int first [NP];
        filt_en = '0;
        write_len(len);
        chk(cfg_rdata == len, "R1 length readback", cfg_rdata, len);
        pin_raw = {NP{pol}};
        repeat (4) @(negedge clk);
        filt_en = '1;
        @(negedge clk);
        chk(pin_out == {NP{pol}}, "R8 clean enable", pin_out, {NP{pol}});
        for (int i = 0; i < NP; i++) begin cnt[i] = 0; first[i] = -1; end
        for (int k = 0; k < len + 42; k++) begin
            @(negedge clk);
            for (int i = 0; i < NP; i++) begin
                if (pin_out[i] != pol) begin
                    cnt[i]++;
                    if (first[i] < 0) first[i] = k;
                end
                pin_raw[i] = (k < i + 1) ? ~pol : pol;
            end
        end
        for (int i = 0; i < NP; i++) begin
            if (i + 1 > len) begin
                chk(cnt[i] == i + 1, len == 0 ? "R5 width" : "R4 width", cnt[i], i + 1);
                chk(first[i] == len + 3, len == 0 ? "R5 latency" : "R4 latency",
                    first[i], len + 3);
            end else begin
                chk(cnt[i] == 0, "R3 absorbed", cnt[i], 0);
            end
        end
        filt_en = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0, c1, f1;
        rst_n = 1'b0; pin_raw = '0; filt_en = '0; cfg_wr = 1'b0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 32'h0, "R1 reset length", cfg_rdata, 0);

        // R7: bypass when disabled.
        foreach (pin_raw[b]) begin end
        pin_raw = 32'hA5C3_0F81; #1;
        chk(pin_out == pin_raw, "R7 bypass", pin_out, pin_raw);
        pin_raw = 32'h5A3C_F07E; #1;
        chk(pin_out == pin_raw, "R7 bypass", pin_out, pin_raw);

        // R1: upper write bits ignored.
        write_len(32'hFFFF_FFEA);
        chk(cfg_rdata == 32'h0000_000A, "R1 upper bits", cfg_rdata, 32'hA);

        // R2: locked while any filter enabled.
        filt_en = 32'h0000_0100;
        write_len(32'h3);
        chk(cfg_rdata == 32'hA, "R2 locked write", cfg_rdata, 32'hA);
        filt_en = 32'h8000_0000;
        write_len(32'h1F);
        chk(cfg_rdata == 32'hA, "R2 locked write", cfg_rdata, 32'hA);
        filt_en = '0;

        // R3 R4 R5 R8 R9: sweeps over length and polarity.
        sweep(0, 1'b0);
        sweep(1, 1'b0);
        sweep(2, 1'b1);
        sweep(7, 1'b0);
        sweep(20, 1'b1);
        sweep(31, 1'b0);
        sweep(31, 1'b1);

        // R6: two 3-cycle glitches split by one cycle (pin 0), versus 3 then 4 (pin 1), len 3.
        write_len(3);
        pin_raw = '0;
        repeat (4) @(negedge clk);
        filt_en = 32'h3;
        c0 = 0; c1 = 0; f1 = -1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (pin_out[0]) c0++;
            if (pin_out[1]) begin c1++; if (f1 < 0) f1 = k; end
            pin_raw[0] = (k < 3) || (k >= 4 && k < 7);
            pin_raw[1] = (k < 3) || (k >= 4 && k < 8);
        end
        chk(c0 == 0, "R6 split glitches absorbed", c0, 0);
        chk(c1 == 4, "R6 second pulse width", c1, 4);
        chk(f1 == 10, "R6 second pulse latency", f1, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule